// File: doc/BRIEF.md
# Chunk Filter Directory Controller

This block is the shared directory that lets per-core scratchpads coexist with the cache hierarchy. It holds a small fully associative table of chunk base addresses that are known to be mapped by no scratchpad. Each entry also carries a sharer mask with one bit per core, showing which cores hold that chunk in their local "safe" filter. Cores send two kinds of request. A query asks whether a chunk may be accessed through the cache path. An invalidation is sent by a core that is about to map a chunk into its own scratchpad.

When a query misses the table, the controller sends a lookup probe to the other cores and gathers their replies. It adds the chunk only when every probed core reports that it has not mapped the chunk. An invalidation that finds its chunk makes every sharer drop the chunk from its filter before the requester is answered. When the table is full, an entry is evicted in round-robin order, and the eviction also invalidates the sharers of that entry. This way no core ever holds a chunk in its filter that is missing from the table. The controller handles one request at a time. Message transport and the per-core logic are outside this block.

Top module: `chunk_filter_dir`

## Requirements
- R1: After reset, reqReady is 1, ansValid is 0, probeValid is 0, and the table is empty.
- R2: A query (reqInval=0) whose chunk is in the table is answered in the cycle after acceptance with ansValid=1 and ansAck=1. No probe is sent, and the requester joins that chunk's sharer mask.
- R3: A query that misses the table produces one single-cycle lookup probe (probeInval=0). Its probeMask has every core bit set except the requester's (bit n means core n). It carries the request address, store flag and store data.
- R4: When every core probed for a query replies with rspHit=0, the chunk is added with only the requester as sharer, and ansAck=1 is returned.
- R5: When any probed core replies with rspHit=1, ansAck=0 is returned and the chunk is not added. For a load (reqStore=0), ansData equals that core's rspData slice (bits n*DATA_W upward). For a store, ansData is 0.
- R6: An invalidation (reqInval=1) whose chunk is not in the table is answered with ansAck=1 in the cycle after acceptance, and no probe is sent.
- R7: An invalidation whose chunk is in the table sends one invalidate probe (probeInval=1) to exactly the chunk's sharers. The chunk is then removed from the table, and ansAck=1 is returned.
- R8: From acceptance until its answer, reqReady stays 0, and request inputs presented during that time are ignored. reqReady returns to 1 in the cycle after the answer.
- R9: If a chunk must be added while all ENTRIES slots are valid, the controller first sends an invalidate probe for the victim slot to that chunk's sharers, and the probe carries the victim's address. Victim slots are taken in round-robin order, starting at slot 0. The victim's slot then receives the new chunk.
- R10: An answer that follows probes appears exactly one cycle after the cycle in which the last probed core's reply is presented, and never while any probed core has not replied.
- R11: Inclusion: the mask of any invalidate probe for a chunk contains every core that was ACKed for that chunk and has not since been invalidated for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to accept |
| reqInval | input | 1 | 1: invalidation request, 0: query |
| reqCore | input | $clog2(NUM_CORES) | Requesting core |
| reqAddr | input | ADDR_W | Chunk base address |
| reqStore | input | 1 | Query is for a store |
| reqData | input | DATA_W | Store data |
| probeValid | output | 1 | Probe pulse to the cores in probeMask |
| probeInval | output | 1 | 1: drop chunk from filter, 0: scratchpad lookup |
| probeMask | output | NUM_CORES | Cores addressed by the probe |
| probeAddr | output | ADDR_W | Chunk address of the probe |
| probeStore | output | 1 | Lookup is for a store |
| probeData | output | DATA_W | Store data for the lookup |
| rspValid | input | NUM_CORES | Reply strobe, one per core |
| rspHit | input | NUM_CORES | Core has the chunk mapped in its scratchpad |
| rspData | input | NUM_CORES*DATA_W | Load data, one slice per core |
| ansValid | output | 1 | Answer pulse to the requester |
| ansCore | output | $clog2(NUM_CORES) | Core being answered |
| ansAck | output | 1 | 1: ACK, 0: NACK |
| ansData | output | DATA_W | Load data returned with a NACK |

## Verification
Two cases put two functions into the same cycle. In the first, several probed cores reply in the same cycle, sometimes with one scratchpad hit among the misses. The pending set must empty in one step, and the hit must still be captured. This is provoked by giving every core a reply delay of zero spread in some operations. The answer cycle and the returned data are then compared with a bench model. In the second, a lookup completes while the table is full, so an eviction and an allocation belong to one request. The bench drives more distinct chunks than there are slots. For each step it predicts the victim address and its sharer mask from its own record of which cores were ACKed.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DECIDE,
    S_WAIT_PROBE,
    S_WAIT_EVICT,
    S_WAIT_INV
  } ctlState_t;

  // strobes from control to datapath, at most a few active per cycle
  typedef struct packed {
    logic latchReq;
    logic setSharer;
    logic issueProbe;
    logic issueEvict;
    logic issueInv;
    logic collect;
    logic captureHit;
    logic allocate;
    logic freeHit;
  } ctlStrobe_t;

endpackage

// File: rtl/cfd_control.sv
module cfd_control
  import cfd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       rqInval,
  input  logic       hitAny,
  input  logic       full,
  input  logic       pendEmpty,
  input  logic       hitSeen,
  output logic       reqReady,
  output logic       ansValid,
  output logic       ansAck,
  output ctlStrobe_t stb
);

  ctlState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    ansValid  = 1'b0;
    ansAck    = 1'b0;
    reqReady  = (state == S_IDLE);
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          stb.latchReq = 1'b1;
          stateNext    = S_DECIDE;
        end
      end
      S_DECIDE: begin
        if (rqInval) begin
          if (hitAny) begin
            stb.issueInv = 1'b1;
            stateNext    = S_WAIT_INV;
          end else begin
            ansValid  = 1'b1;
            ansAck    = 1'b1;
            stateNext = S_IDLE;
          end
        end else if (hitAny) begin
          stb.setSharer = 1'b1;
          ansValid      = 1'b1;
          ansAck        = 1'b1;
          stateNext     = S_IDLE;
        end else begin
          stb.issueProbe = 1'b1;
          stateNext      = S_WAIT_PROBE;
        end
      end
      S_WAIT_PROBE: begin
        stb.collect    = 1'b1;
        stb.captureHit = 1'b1;
        if (pendEmpty) begin
          if (hitSeen) begin
            ansValid  = 1'b1;
            stateNext = S_IDLE;
          end else if (full) begin
            stb.issueEvict = 1'b1;
            stateNext      = S_WAIT_EVICT;
          end else begin
            stb.allocate = 1'b1;
            ansValid     = 1'b1;
            ansAck       = 1'b1;
            stateNext    = S_IDLE;
          end
        end
      end
      S_WAIT_EVICT: begin
        stb.collect = 1'b1;
        if (pendEmpty) begin
          stb.allocate = 1'b1;
          ansValid     = 1'b1;
          ansAck       = 1'b1;
          stateNext    = S_IDLE;
        end
      end
      S_WAIT_INV: begin
        stb.collect = 1'b1;
        if (pendEmpty) begin
          stb.freeHit = 1'b1;
          ansValid    = 1'b1;
          ansAck      = 1'b1;
          stateNext   = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  // R8: accepting a request closes the door until the answer
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R8: the cycle after an answer the controller is free again
  p_free_after_answer_r8: assert property (@(posedge clk) disable iff (!rstN)
    ansValid |=> reqReady);

endmodule

// File: rtl/cfd_datapath.sv
module cfd_datapath
  import cfd_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ENTRIES   = 8,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  localparam int CORE_W   = $clog2(NUM_CORES),
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctlStrobe_t                  stb,
  input  logic                        reqInval,
  input  logic [CORE_W-1:0]           reqCore,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic                        reqStore,
  input  logic [DATA_W-1:0]           reqData,
  input  logic [NUM_CORES-1:0]        rspValid,
  input  logic [NUM_CORES-1:0]        rspHit,
  input  logic [NUM_CORES*DATA_W-1:0] rspData,
  output logic                        rqInval,
  output logic                        hitAny,
  output logic                        full,
  output logic                        pendEmpty,
  output logic                        hitSeen,
  output logic                        probeValid,
  output logic                        probeInval,
  output logic [NUM_CORES-1:0]        probeMask,
  output logic [ADDR_W-1:0]           probeAddr,
  output logic                        probeStore,
  output logic [DATA_W-1:0]           probeData,
  output logic [CORE_W-1:0]           ansCore,
  output logic [DATA_W-1:0]           ansData
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0]   entValid;
  logic [ADDR_W-1:0]    entTag  [ENTRIES];
  logic [NUM_CORES-1:0] entMask [ENTRIES];
  logic [IDX_W-1:0]     victimPtr;

  logic [CORE_W-1:0]    rqCore;
  logic [ADDR_W-1:0]    rqAddr;
  logic                 rqStore;
  logic [DATA_W-1:0]    rqData;
  logic [NUM_CORES-1:0] pend;
  logic [DATA_W-1:0]    capData;

  logic [ENTRIES-1:0]   hitVec;
  logic [IDX_W-1:0]     hitIdx, freeIdx, allocIdx;
  logic [NUM_CORES-1:0] reqBit;
  logic                 anyIssue;

  // associative compare, one comparator per slot
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hitVec[i] = entValid[i] && (entTag[i] == rqAddr);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hitVec[i]) hitIdx = IDX_W'(i);
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!entValid[i]) freeIdx = IDX_W'(i);
  end

  assign hitAny    = |hitVec;
  assign full      = &entValid;
  assign allocIdx  = full ? victimPtr : freeIdx;
  assign reqBit    = NUM_CORES'(1) << rqCore;
  assign pendEmpty = (pend == '0);
  assign anyIssue  = stb.issueProbe | stb.issueEvict | stb.issueInv;

  // probe formation
  always_comb begin
    probeValid = anyIssue;
    probeInval = !stb.issueProbe;
    probeStore = stb.issueProbe & rqStore;
    probeData  = stb.issueProbe ? rqData : '0;
    probeAddr  = stb.issueEvict ? entTag[victimPtr] : rqAddr;
    if (stb.issueProbe)      probeMask = ~reqBit;
    else if (stb.issueEvict) probeMask = entMask[victimPtr];
    else if (stb.issueInv)   probeMask = entMask[hitIdx];
    else                     probeMask = '0;
  end

  assign ansCore = rqCore;
  assign ansData = capData;

  // table storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid  <= '0;
      victimPtr <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        entTag[i]  <= '0;
        entMask[i] <= '0;
      end
    end else begin
      if (stb.setSharer)
        entMask[hitIdx] <= entMask[hitIdx] | reqBit;
      if (stb.allocate) begin
        entValid[allocIdx] <= 1'b1;
        entTag[allocIdx]   <= rqAddr;
        entMask[allocIdx]  <= reqBit;
        if (full) victimPtr <= (victimPtr == LAST_IDX) ? '0 : victimPtr + 1'b1;
      end
      if (stb.freeHit) begin
        entValid[hitIdx] <= 1'b0;
        entMask[hitIdx]  <= '0;
      end
    end
  end

  // request latch, pending set and reply capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rqInval <= 1'b0;
      rqCore  <= '0;
      rqAddr  <= '0;
      rqStore <= 1'b0;
      rqData  <= '0;
      pend    <= '0;
      hitSeen <= 1'b0;
      capData <= '0;
    end else begin
      if (stb.latchReq) begin
        rqInval <= reqInval;
        rqCore  <= reqCore;
        rqAddr  <= reqAddr;
        rqStore <= reqStore;
        rqData  <= reqData;
        hitSeen <= 1'b0;
        capData <= '0;
      end
      if (anyIssue)         pend <= probeMask;
      else if (stb.collect) pend <= pend & ~rspValid;
      if (stb.captureHit) begin
        for (int c = 0; c < NUM_CORES; c++) begin
          if (pend[c] && rspValid[c] && rspHit[c]) begin
            hitSeen <= 1'b1;
            if (!rqStore) capData <= rspData[c*DATA_W +: DATA_W];
          end
        end
      end
    end
  end

  // R4: a chunk is only added when it is absent, so tags stay unique
  p_alloc_fresh_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.allocate |-> !hitAny);

  // R10: collecting replies never adds cores to the pending set
  p_pend_shrinks_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.collect && !anyIssue) |=> ((pend & ~$past(pend)) == '0));

  // R11: every live entry has at least one sharer
  for (genvar i = 0; i < ENTRIES; i++) begin : g_own
    p_entry_owned_r11: assert property (@(posedge clk) disable iff (!rstN)
      entValid[i] |-> (entMask[i] != '0));
  end

endmodule

// File: rtl/chunk_filter_dir.sv
module chunk_filter_dir
  import cfd_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ENTRIES   = 8,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic                        reqInval,
  input  logic [CORE_W-1:0]           reqCore,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic                        reqStore,
  input  logic [DATA_W-1:0]           reqData,
  output logic                        probeValid,
  output logic                        probeInval,
  output logic [NUM_CORES-1:0]        probeMask,
  output logic [ADDR_W-1:0]           probeAddr,
  output logic                        probeStore,
  output logic [DATA_W-1:0]           probeData,
  input  logic [NUM_CORES-1:0]        rspValid,
  input  logic [NUM_CORES-1:0]        rspHit,
  input  logic [NUM_CORES*DATA_W-1:0] rspData,
  output logic                        ansValid,
  output logic [CORE_W-1:0]           ansCore,
  output logic                        ansAck,
  output logic [DATA_W-1:0]           ansData
);

  ctlStrobe_t stb;
  logic rqInval, hitAny, full, pendEmpty, hitSeen;

  cfd_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .rqInval   (rqInval),
    .hitAny    (hitAny),
    .full      (full),
    .pendEmpty (pendEmpty),
    .hitSeen   (hitSeen),
    .reqReady  (reqReady),
    .ansValid  (ansValid),
    .ansAck    (ansAck),
    .stb       (stb)
  );

  cfd_datapath #(
    .NUM_CORES (NUM_CORES),
    .ENTRIES   (ENTRIES),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .reqInval   (reqInval),
    .reqCore    (reqCore),
    .reqAddr    (reqAddr),
    .reqStore   (reqStore),
    .reqData    (reqData),
    .rspValid   (rspValid),
    .rspHit     (rspHit),
    .rspData    (rspData),
    .rqInval    (rqInval),
    .hitAny     (hitAny),
    .full       (full),
    .pendEmpty  (pendEmpty),
    .hitSeen    (hitSeen),
    .probeValid (probeValid),
    .probeInval (probeInval),
    .probeMask  (probeMask),
    .probeAddr  (probeAddr),
    .probeStore (probeStore),
    .probeData  (probeData),
    .ansCore    (ansCore),
    .ansData    (ansData)
  );

  // R3: probes are single-cycle pulses
  p_probe_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    probeValid |=> !probeValid);

  // R10: no answer while a probed core is still outstanding
  p_answer_after_replies_r10: assert property (@(posedge clk) disable iff (!rstN)
    ansValid |-> pendEmpty);

endmodule

// File: tb/chunk_filter_dir_bench.sv
module chunk_filter_dir_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NC  = 4;
  localparam int NE  = 4;
  localparam int AW  = 8;
  localparam int DW  = 8;
  localparam int NCH = 8;
  localparam int CW  = $clog2(NC);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqInval = 1'b0, reqStore = 1'b0;
  logic [CW-1:0] reqCore = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic reqReady, probeValid, probeInval, probeStore, ansValid, ansAck;
  logic [NC-1:0] probeMask;
  logic [AW-1:0] probeAddr;
  logic [DW-1:0] probeData, ansData;
  logic [CW-1:0] ansCore;
  logic [NC-1:0] rspValid = '0, rspHit = '0;
  logic [NC*DW-1:0] rspData = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chunk_filter_dir #(.NUM_CORES(NC), .ENTRIES(NE), .ADDR_W(AW), .DATA_W(DW)) u_chunk_filter_dir (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqInval(reqInval),
    .reqCore(reqCore), .reqAddr(reqAddr), .reqStore(reqStore), .reqData(reqData),
    .probeValid(probeValid), .probeInval(probeInval), .probeMask(probeMask),
    .probeAddr(probeAddr), .probeStore(probeStore), .probeData(probeData),
    .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData),
    .ansValid(ansValid), .ansCore(ansCore), .ansAck(ansAck), .ansData(ansData));

  int errors = 0;
  int checks = 0;
  bit filtHas [NC][NCH];
  int spmOwner [NCH];
  int refTag [NE];
  bit refValid [NE];
  int refPtr = 0;
  int lfsr = 32'h1ACE5;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] coreData(input int c, input int a);
    return DW'(c * 37 + a * 5 + 1);
  endfunction

  function automatic int filtMask(input int a);
    int m = 0;
    for (int c = 0; c < NC; c++) if (filtHas[c][a]) m |= (1 << c);
    return m;
  endfunction

  function automatic int refFind(input int a);
    for (int i = 0; i < NE; i++) if (refValid[i] && refTag[i] == a) return i;
    return -1;
  endfunction

  task automatic runOp(input int core, input bit inval, input int a, input bit store,
                       input int data, input int spread);
    int nProbe = 0;
    int pMask[2], pInval[2], pAddr[2], pStore[2], pData[2];
    int cnt[NC];
    int lastRsp = 0, ansNeg = 0, aAck = -1, aData = -1, aCore = -1;
    int curChunk = a;
    bit curInv = 0;
    int expProbes, expAck, expData, slot, vic, hitSlot;
    int expMask0 = 0, expMask1 = 0, expAddr1 = 0;
    for (int c = 0; c < NC; c++) cnt[c] = 0;

    // expected outcome from the model, before updating it
    hitSlot = refFind(a);
    expData = 0;
    vic = -1;
    if (inval) begin
      expAck = 1;
      if (hitSlot >= 0) begin expProbes = 1; expMask0 = filtMask(a); end
      else expProbes = 0;
    end else if (hitSlot >= 0) begin
      expProbes = 0; expAck = 1;
    end else begin
      expMask0 = ((1 << NC) - 1) & ~(1 << core);
      if (spmOwner[a] >= 0 && spmOwner[a] != core) begin
        expProbes = 1; expAck = 0;
        expData = store ? 0 : int'(coreData(spmOwner[a], a));
      end else begin
        expAck = 1;
        if (refValid[0] && refValid[1] && refValid[2] && refValid[3]) begin
          vic = refPtr; expProbes = 2;
          expAddr1 = refTag[vic] * 8; expMask1 = filtMask(refTag[vic]);
        end else expProbes = 1;
      end
    end

    @(negedge clk);
    chk("R8 ready before request", int'(reqReady), 1);
    reqValid = 1'b1; reqInval = inval; reqCore = CW'(core);
    reqAddr = AW'(a * 8); reqStore = store; reqData = DW'(data);

    for (int n = 1; n <= 60; n++) begin
      @(negedge clk);
      if (n == 1) begin
        // a competing request held during the busy period must be ignored
        reqInval = ~inval; reqCore = CW'((core + 1) % NC); reqAddr = 8'hFF; reqData = 8'hEE;
      end
      rspValid = '0;
      for (int c = 0; c < NC; c++) begin
        if (cnt[c] == 1) begin
          rspValid[c] = 1'b1;
          rspHit[c]   = !curInv && (spmOwner[curChunk] == c);
          rspData[c*DW +: DW] = coreData(c, curChunk);
          lastRsp = n;
        end
        if (cnt[c] > 0) cnt[c]--;
      end
      if (probeValid && nProbe < 2) begin
        pMask[nProbe] = int'(probeMask); pInval[nProbe] = int'(probeInval);
        pAddr[nProbe] = int'(probeAddr); pStore[nProbe] = int'(probeStore);
        pData[nProbe] = int'(probeData);
        curInv = probeInval; curChunk = int'(probeAddr) / 8;
        for (int c = 0; c < NC; c++)
          if (probeMask[c]) cnt[c] = 1 + ((spread == 0) ? 0 : ((c * spread) % 3));
        nProbe++;
      end
      if (ansValid) begin
        ansNeg = n; aAck = int'(ansAck); aData = int'(ansData); aCore = int'(ansCore);
        chk("R8 busy at answer", int'(reqReady), 0);
        reqValid = 1'b0;
        break;
      end
      chk("R8 ready low while busy", int'(reqReady), 0);
    end
    reqValid = 1'b0;
    rspValid = '0;

    if (ansNeg == 0) begin
      errors++; checks++;
      $display("FAIL R10 no answer actual=0 expected=1");
      return;
    end
    chk("R8 answer core", aCore, core);
    chk(inval ? "R7 answer ack" : "R4 R5 answer ack", aAck, expAck);
    chk("R5 answer data", aData, expData);
    chk("R3 R7 R9 probe count", nProbe, expProbes);
    if (expProbes == 0)
      chk(inval ? "R6 answer cycle" : "R2 answer cycle", ansNeg, 1);
    else
      chk("R10 answer after last reply", ansNeg, lastRsp + 1);
    if (expProbes >= 1 && nProbe >= 1) begin
      chk(inval ? "R7 R11 inval mask" : "R3 lookup mask", pMask[0], expMask0);
      chk("R3 R7 probe kind", pInval[0], inval ? 1 : 0);
      chk("R3 probe addr", pAddr[0], a * 8);
      if (!inval) begin
        chk("R3 probe store", pStore[0], store ? 1 : 0);
        chk("R3 probe data", pData[0], data & 8'hFF);
      end
    end
    if (expProbes == 2 && nProbe == 2) begin
      chk("R9 R11 evict mask", pMask[1], expMask1);
      chk("R9 evict kind", pInval[1], 1);
      chk("R9 evict addr", pAddr[1], expAddr1);
    end

    // model update
    if (inval) begin
      if (hitSlot >= 0) begin
        for (int c = 0; c < NC; c++) filtHas[c][a] = 0;
        refValid[hitSlot] = 0;
      end
      spmOwner[a] = core;
    end else if (hitSlot >= 0) begin
      filtHas[core][a] = 1;
    end else if (expAck == 1) begin
      if (vic >= 0) begin
        for (int c = 0; c < NC; c++) filtHas[c][refTag[vic]] = 0;
        slot = vic;
        refPtr = (refPtr + 1) % NE;
      end else begin
        slot = -1;
        for (int i = NE - 1; i >= 0; i--) if (!refValid[i]) slot = i;
      end
      refValid[slot] = 1; refTag[slot] = a;
      filtHas[core][a] = 1;
    end
  endtask

  initial begin
    for (int a = 0; a < NCH; a++) spmOwner[a] = -1;
    for (int i = 0; i < NE; i++) begin refValid[i] = 0; refTag[i] = 0; end
    for (int c = 0; c < NC; c++) for (int a = 0; a < NCH; a++) filtHas[c][a] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", int'(reqReady), 1);
    chk("R1 reset ansValid", int'(ansValid), 0);
    chk("R1 reset probeValid", int'(probeValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(reqReady), 1);

    // R6 on empty table
    runOp(1, 1, 7, 0, 0, 0);           // core 1 maps chunk 7
    // R4 allocation, replies all in one cycle
    runOp(0, 0, 0, 0, 0, 0);
    // R2 hits from other cores grow the sharer mask
    runOp(2, 0, 0, 0, 0, 1);
    runOp(3, 0, 0, 1, 9, 2);
    // R5 load and store to a chunk mapped by core 1
    runOp(0, 0, 7, 0, 0, 0);
    runOp(2, 0, 7, 1, 77, 1);
    // R7 R11 invalidation with three sharers
    runOp(1, 1, 0, 0, 0, 2);
    // R9 fill and overflow the table
    runOp(0, 0, 1, 0, 0, 1);
    runOp(1, 0, 2, 0, 0, 0);
    runOp(2, 0, 3, 1, 5, 2);
    runOp(3, 0, 4, 0, 0, 1);
    runOp(0, 0, 2, 0, 0, 0);
    runOp(2, 0, 5, 0, 0, 1);
    runOp(3, 0, 6, 0, 0, 2);

    // near-exhaustive pseudo-random sweep over cores, chunks and kinds
    for (int k = 0; k < 400; k++) begin
      int r, core, a;
      bit inv;
      lfsr = (lfsr * 1103515245 + 12345) & 32'h7FFFFFFF;
      r = lfsr >> 4;
      core = r % NC;
      a = (r >> 2) % NCH;
      inv = ((r >> 5) % 6) == 0;
      if (!inv && spmOwner[a] == core) core = (core + 1) % NC;
      runOp(core, inv, a, (r >> 8) & 1, (r >> 9) & 255, (r >> 3) % 3);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule